// File: doc/BRIEF.md
# SMBus EEPROM Configuration Loader

This block runs once after every reset and fills on-chip registers from a serial EEPROM. It is an SMBus/I2C master with open-drain outputs. It reads a list of configuration records from the EEPROM and turns each record into one write on a simple internal register bus. That bus has a one-cycle strobe, a byte address and 32-bit data.

While reset is held, the block samples its strap inputs. A speed strap selects a slow (100 kHz class) or fast (400 kHz class) SCL rate. A 4-bit mode value decides whether a load takes place at all. Four address straps complete the EEPROM device address. Each record holds a 16-bit doubleword register address and 32 bits of data, both least significant byte first. Records are stored only for the registers that need a value, and a doubleword address of 0xFFFF ends the list. When the load finishes, `done` rises. `error` rises with it if the EEPROM failed to acknowledge an address or offset byte.

Top module: `eeload_top`

## Requirements
- R1: The speed strap sampled in reset sets the SCL timing. When the strap is high, SCL stays released for 2×Q_SLOW system clocks per bit and held low for 2×Q_SLOW. When the strap is low, Q_FAST is used in place of Q_SLOW.
- R2: The device address byte is built as follows. Bits 7:5 are 1,0,1. Bits 4:1 are the address straps, with strap bit 3 in byte bit 4. Bit 0 is the direction bit, 0 for write and 1 for read.
- R3: A load accesses the bus in this order: START, device address with write, offset byte 0x00 (high), offset byte 0x00 (low), repeated START, device address with read. These are the only two START conditions in a load.
- R4: Each record is six bytes read in order: doubleword address low byte, doubleword address high byte, then data bytes from least to most significant. Each record produces exactly one register write, in EEPROM order. `reg_addr` is the doubleword address shifted left by two and `reg_wdata` is the 32-bit data. A data value of 0xFFFFFFFF is written like any other value.
- R5: A doubleword address of 0xFFFF ends the list. The block then reads one more byte, leaves SDA released in that byte's acknowledge slot (NACK), issues STOP, and raises `done` with `error` low.
- R6: Loading happens only when bit `mode_strap` of parameter LOAD_MODES is set (by default modes 1 and 3). For any other mode, `done` is high on the second clock edge after reset release and neither SCL nor SDA is ever driven.
- R7: Either `rst` or `hot_rst` clears `done` and `error`, releases both lines, re-samples all straps and starts a new load when it is released.
- R8: If the EEPROM does not acknowledge a device address or offset byte, the block issues STOP at once and then asserts both `error` and `done`. No register write takes place.
- R9: While SCL is released, SDA changes only to form a START or STOP. Received bits are sampled in the middle of the SCL high time.
- R10: `done` stays high until the next reset, and every register write strobe lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Fundamental reset, synchronous, active high |
| hot_rst | input | 1 | Hot reset, synchronous, active high |
| slow_strap | input | 1 | Speed strap, 1 selects the slow SCL rate |
| mode_strap | input | 4 | Operating mode value, sampled in reset |
| addr_strap | input | 4 | Low four bits of the EEPROM device address |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | 18 | Register byte address |
| reg_wdata | output | 32 | Register write data |
| done | output | 1 | Load sequence finished |
| error | output | 1 | Load stopped on a missing acknowledge |

## Verification
The bench drives full loads against a behavioural EEPROM slave twice. The first load uses fundamental reset with the fast speed strap. The second uses hot reset with the slow speed strap and a different address strap. These two loads separate the prescaler choice, the strap-built address bytes and the reset sources. The record list includes a high doubleword address and an all-ones data word, which tells the address shift and the terminator test apart from plain data. A mode that is not in the load set checks that the block finishes without touching the bus. A device address mismatch checks the error path, which must give STOP, error and no writes.

// File: rtl/eeload_pkg.sv
package eeload_pkg;

    localparam int DATA_W      = 32;
    localparam int DWA_W       = 16;
    localparam int BYTE_ADDR_W = DWA_W + 2;
    localparam int REC_BYTES   = (DWA_W + DATA_W) / 8;
    localparam int REC_W       = REC_BYTES * 8;
    localparam logic [DWA_W-1:0] LIST_END = '1;

    typedef enum logic [1:0] {
        K_START,
        K_STOP,
        K_WRITE,
        K_READ
    } bus_cmd_e;

    typedef struct packed {
        bus_cmd_e   kind;
        logic [7:0] wbyte;
        logic       ack_out;
    } bus_req_t;

    typedef struct packed {
        logic [7:0] rbyte;
        logic       acked;
    } bus_rsp_t;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_START,
        SQ_DEVW,
        SQ_OFFH,
        SQ_OFFL,
        SQ_RSTART,
        SQ_DEVR,
        SQ_READ,
        SQ_TAIL,
        SQ_WRITE,
        SQ_STOP,
        SQ_DONE
    } seq_state_e;

    function automatic logic [7:0] dev_byte(input logic [3:0] strap, input logic rd);
        return {3'b101, strap, rd};
    endfunction

    function automatic logic is_load_mode(input logic [15:0] set, input logic [3:0] m);
        return set[m];
    endfunction

endpackage

// File: rtl/eeload_tick.sv
module eeload_tick #(
    parameter int Q_FAST = 78,
    parameter int Q_SLOW = 312
) (
    input  logic clk,
    input  logic rst,
    input  logic slow,
    output logic tick
);
    localparam int QMAX = (Q_SLOW > Q_FAST) ? Q_SLOW : Q_FAST;
    localparam int CW   = $clog2(QMAX + 1);
    localparam logic [CW-1:0] LIM_F = CW'(Q_FAST - 1);
    localparam logic [CW-1:0] LIM_S = CW'(Q_SLOW - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit = slow ? LIM_S : LIM_F;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= limit) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R1: quarter-period ticks never come back to back (dividers are at least 2)
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/eeload_phy.sv
module eeload_phy
    import eeload_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     req_valid,
    input  bus_req_t req,
    output logic     rsp_valid,
    output bus_rsp_t rsp,
    input  logic     sda_in,
    output logic     scl_oe,
    output logic     sda_oe
);
    logic       busy;
    logic [1:0] q;
    logic [3:0] bitn;
    logic [7:0] sh;
    logic       acked;
    logic       scl_low;
    logic       sda_low;
    bus_cmd_e   kind;
    logic       ack_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            q         <= '0;
            bitn      <= '0;
            sh        <= '0;
            acked     <= 1'b0;
            scl_low   <= 1'b0;
            sda_low   <= 1'b0;
            kind      <= K_STOP;
            ack_out   <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (!busy) begin
                if (req_valid) begin
                    busy    <= 1'b1;
                    kind    <= req.kind;
                    ack_out <= req.ack_out;
                    sh      <= req.wbyte;
                    q       <= '0;
                    bitn    <= '0;
                end
            end else if (tick) begin
                q <= q + 1'b1;
                unique case (kind)
                    K_START: begin
                        unique case (q)
                            2'd0: sda_low <= 1'b0;
                            2'd1: scl_low <= 1'b0;
                            2'd2: sda_low <= 1'b1;
                            default: begin
                                scl_low   <= 1'b1;
                                busy      <= 1'b0;
                                rsp_valid <= 1'b1;
                            end
                        endcase
                    end
                    K_STOP: begin
                        unique case (q)
                            2'd0: sda_low <= 1'b1;
                            2'd1: scl_low <= 1'b0;
                            2'd2: sda_low <= 1'b0;
                            default: begin
                                busy      <= 1'b0;
                                rsp_valid <= 1'b1;
                            end
                        endcase
                    end
                    default: begin
                        unique case (q)
                            2'd0: begin
                                if (bitn == 4'd8)
                                    sda_low <= (kind == K_READ) ? ack_out : 1'b0;
                                else
                                    sda_low <= (kind == K_WRITE) ? ~sh[7] : 1'b0;
                            end
                            2'd1: scl_low <= 1'b0;
                            2'd2: begin
                                if (bitn == 4'd8) acked <= ~sda_in;
                                else              sh    <= {sh[6:0], sda_in};
                            end
                            default: begin
                                scl_low <= 1'b1;
                                if (bitn == 4'd8) begin
                                    busy      <= 1'b0;
                                    rsp_valid <= 1'b1;
                                end else begin
                                    bitn <= bitn + 1'b1;
                                end
                            end
                        endcase
                    end
                endcase
            end
        end
    end

    assign rsp.rbyte = sh;
    assign rsp.acked = acked;
    assign scl_oe    = scl_low;
    assign sda_oe    = sda_low;

    // R9: with SCL released, SDA may only move as part of START or STOP
    assert_sda_edge_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !scl_low && !$past(scl_low) && (sda_low != $past(sda_low)))
        |-> (kind == K_START || kind == K_STOP));

    // R1: SCL only moves one cycle after a prescaler tick
    assert_scl_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (scl_low != $past(scl_low))) |-> $past(tick));

endmodule

// File: rtl/eeload_seq.sv
module eeload_seq
    import eeload_pkg::*;
#(
    parameter logic [15:0] LOAD_MODES = 16'h000A
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   slow_strap,
    input  logic [3:0]             mode_strap,
    input  logic [3:0]             addr_strap,
    output logic                   slow_sel,
    output logic                   req_valid,
    output bus_req_t               req,
    input  logic                   rsp_valid,
    input  bus_rsp_t               rsp,
    output logic                   reg_we,
    output logic [BYTE_ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0]      reg_wdata,
    output logic                   done,
    output logic                   error
);
    seq_state_e       st;
    logic             pend;
    logic [2:0]       cnt;
    logic [REC_W-1:0] rec;
    logic [3:0]       strap_q;
    logic [3:0]       mode_q;
    logic             err;
    logic             bus_state;
    logic             ack_needed;

    always_comb begin
        bus_state  = !(st inside {SQ_IDLE, SQ_WRITE, SQ_DONE});
        ack_needed = st inside {SQ_DEVW, SQ_OFFH, SQ_OFFL, SQ_DEVR};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            pend     <= 1'b0;
            cnt      <= '0;
            rec      <= '0;
            err      <= 1'b0;
            strap_q  <= addr_strap;
            mode_q   <= mode_strap;
            slow_sel <= slow_strap;
        end else begin
            unique case (st)
                SQ_IDLE:  st <= is_load_mode(LOAD_MODES, mode_q) ? SQ_START : SQ_DONE;
                SQ_WRITE: begin
                    cnt <= '0;
                    st  <= SQ_READ;
                end
                SQ_DONE:  st <= SQ_DONE;
                default: begin
                    if (!pend) begin
                        pend <= 1'b1;
                    end else if (rsp_valid) begin
                        pend <= 1'b0;
                        if (ack_needed && !rsp.acked) begin
                            err <= 1'b1;
                            st  <= SQ_STOP;
                        end else begin
                            unique case (st)
                                SQ_START:  st <= SQ_DEVW;
                                SQ_DEVW:   st <= SQ_OFFH;
                                SQ_OFFH:   st <= SQ_OFFL;
                                SQ_OFFL:   st <= SQ_RSTART;
                                SQ_RSTART: st <= SQ_DEVR;
                                SQ_DEVR: begin
                                    cnt <= '0;
                                    st  <= SQ_READ;
                                end
                                SQ_READ: begin
                                    rec <= {rsp.rbyte, rec[REC_W-1:8]};
                                    if (cnt == 3'd1 && {rsp.rbyte, rec[REC_W-1 -: 8]} == LIST_END)
                                        st <= SQ_TAIL;
                                    else if (cnt == 3'(REC_BYTES - 1))
                                        st <= SQ_WRITE;
                                    else
                                        cnt <= cnt + 1'b1;
                                end
                                SQ_TAIL: st <= SQ_STOP;
                                default: st <= SQ_DONE;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        req = '{kind: K_WRITE, wbyte: 8'h00, ack_out: 1'b0};
        unique case (st)
            SQ_START, SQ_RSTART: req.kind = K_START;
            SQ_DEVW:             req.wbyte = dev_byte(strap_q, 1'b0);
            SQ_DEVR:             req.wbyte = dev_byte(strap_q, 1'b1);
            SQ_READ:             req = '{kind: K_READ, wbyte: 8'h00, ack_out: 1'b1};
            SQ_TAIL:             req.kind = K_READ;
            SQ_STOP:             req.kind = K_STOP;
            default:             req.kind = K_WRITE;
        endcase
    end

    assign req_valid = bus_state && !pend;
    assign reg_we    = (st == SQ_WRITE);
    assign reg_addr  = {rec[DWA_W-1:0], 2'b00};
    assign reg_wdata = rec[REC_W-1:DWA_W];
    assign done      = (st == SQ_DONE);
    assign error     = err;

    // R10: done holds until a reset
    assert_done_holds_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R10: a register write strobe is a single cycle
    assert_we_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R8: once an acknowledge is missing, no register write follows
    assert_err_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        error |-> !reg_we);

    // R6: a finished sequencer issues no more bus commands
    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_valid);

endmodule

// File: rtl/eeload_top.sv
module eeload_top
    import eeload_pkg::*;
#(
    parameter int          Q_FAST     = 78,
    parameter int          Q_SLOW     = 312,
    parameter logic [15:0] LOAD_MODES = 16'h000A
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   hot_rst,
    input  logic                   slow_strap,
    input  logic [3:0]             mode_strap,
    input  logic [3:0]             addr_strap,
    input  logic                   sda_in,
    output logic                   scl_oe,
    output logic                   sda_oe,
    output logic                   reg_we,
    output logic [BYTE_ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0]      reg_wdata,
    output logic                   done,
    output logic                   error
);
    logic     rst_any;
    logic     slow_sel;
    logic     tick;
    logic     req_valid;
    bus_req_t req;
    logic     rsp_valid;
    bus_rsp_t rsp;

    assign rst_any = rst | hot_rst;

    eeload_tick #(
        .Q_FAST(Q_FAST),
        .Q_SLOW(Q_SLOW)
    ) u_tick (
        .clk (clk),
        .rst (rst_any),
        .slow(slow_sel),
        .tick(tick)
    );

    eeload_phy u_phy (
        .clk      (clk),
        .rst      (rst_any),
        .tick     (tick),
        .req_valid(req_valid),
        .req      (req),
        .rsp_valid(rsp_valid),
        .rsp      (rsp),
        .sda_in   (sda_in),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe)
    );

    eeload_seq #(
        .LOAD_MODES(LOAD_MODES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst_any),
        .slow_strap(slow_strap),
        .mode_strap(mode_strap),
        .addr_strap(addr_strap),
        .slow_sel  (slow_sel),
        .req_valid (req_valid),
        .req       (req),
        .rsp_valid (rsp_valid),
        .rsp       (rsp),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .done      (done),
        .error     (error)
    );

    // R7: any reset leaves both lines released
    assert_reset_release_R7: assert property (@(posedge clk)
        $past(rst_any) |-> (!scl_oe && !sda_oe && !done));

endmodule

// File: tb/eeload_top_test.sv
module eeload_top_test;
    localparam int QF = 3;
    localparam int QS = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hot_rst = 1'b0;
    logic        slow_strap = 1'b0;
    logic [3:0]  mode_strap = 4'd1;
    logic [3:0]  addr_strap = 4'd0;
    logic        sda_in;
    logic        scl_oe, sda_oe, reg_we, done, error;
    logic [17:0] reg_addr;
    logic [31:0] reg_wdata;

    always #4 clk = ~clk;

    eeload_top #(.Q_FAST(QF), .Q_SLOW(QS), .LOAD_MODES(16'h000A)) uut (
        .clk(clk), .rst(rst), .hot_rst(hot_rst), .slow_strap(slow_strap),
        .mode_strap(mode_strap), .addr_strap(addr_strap), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .done(done), .error(error));

    // open-drain lines with pull-ups
    logic s_low = 1'b0;
    logic scl_ln, sda_ln;
    assign scl_ln = ~scl_oe;
    assign sda_ln = ~(sda_oe | s_low);
    assign sda_in = sda_ln;

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural EEPROM slave and bus monitor
    logic [7:0]  mem [64];
    logic [6:0]  s_addr = 7'h53;
    int          sst = 0, bitn = 0, txn = 0;
    logic [7:0]  sh = 8'h00, txb = 8'h00;
    logic [15:0] ptr = 16'h0000;
    bit          ackph = 0;
    logic        prev_scl = 1'b1, prev_sda = 1'b1;
    int          n_start = 0, n_stop = 0, n_rd = 0, n_we = 0, scl_act = 0, hcnt = 0;
    bit          last_nack = 0;
    logic [7:0]  wq[$];
    int          hq[$];
    logic [49:0] expq[$];

    task automatic clear_mon();
        sst = 0; bitn = 0; txn = 0; ackph = 0; s_low = 1'b0; ptr = 16'h0000;
        n_start = 0; n_stop = 0; n_rd = 0; n_we = 0; scl_act = 0; hcnt = 0;
        last_nack = 0; wq.delete(); hq.delete();
    endtask

    always @(negedge clk) begin
        if (scl_oe) scl_act++;
        if (prev_scl && scl_ln && prev_sda && !sda_ln) begin
            n_start++; sst = 1; bitn = 0; ackph = 0; s_low = 1'b0;
        end else if (prev_scl && scl_ln && !prev_sda && sda_ln) begin
            n_stop++; sst = 0; s_low = 1'b0;
        end else if (!prev_scl && scl_ln) begin
            if (sst >= 1 && sst <= 3 && bitn < 8) begin
                sh = {sh[6:0], sda_ln}; bitn++;
            end else if (sst == 4) begin
                if (txn < 8) txn++;
                else begin
                    n_rd++;
                    if (sda_ln) begin last_nack = 1; sst = 0; end
                    else begin last_nack = 0; ptr++; txb = mem[ptr[5:0]]; txn = 0; end
                end
            end
        end else if (prev_scl && !scl_ln) begin
            if (sst >= 1 && sst <= 3) begin
                if (bitn == 8 && !ackph) begin
                    wq.push_back(sh);
                    if (sst != 1 || sh[7:1] == s_addr) begin s_low = 1'b1; ackph = 1; end
                    else sst = 0;
                end else if (ackph) begin
                    ackph = 0; s_low = 1'b0; bitn = 0;
                    if (sst == 1) begin
                        if (sh[0]) begin
                            sst = 4; txn = 0; txb = mem[ptr[5:0]]; s_low = ~txb[7];
                        end else sst = 2;
                    end else if (sst == 2) begin ptr[15:8] = sh; sst = 3; end
                    else begin ptr[7:0] = sh; sst = 0; end
                end
            end else if (sst == 4) begin
                if (txn < 8) s_low = ~txb[7 - txn];
                else         s_low = 1'b0;
            end
        end
        if (scl_ln) hcnt++;
        else if (prev_scl) begin hq.push_back(hcnt); hcnt = 0; end
        prev_scl = scl_ln;
        prev_sda = sda_ln;
        // reference model: every clock, a write strobe must match the next expected record (R4)
        if (reg_we) begin
            n_we++;
            if (expq.size() == 0) chk(0, "R4 unexpected write", {reg_addr, reg_wdata}, 0);
            else begin
                logic [49:0] e;
                e = expq.pop_front();
                chk({reg_addr, reg_wdata} == e, "R4 write addr/data", {reg_addr, reg_wdata}, e);
            end
        end
    end

    task automatic put_rec(input int at, input logic [15:0] dw, input logic [31:0] d, input bit expect_it);
        mem[at]   = dw[7:0];   mem[at+1] = dw[15:8];
        mem[at+2] = d[7:0];    mem[at+3] = d[15:8];
        mem[at+4] = d[23:16];  mem[at+5] = d[31:24];
        if (expect_it) expq.push_back({dw, 2'b00, d});
    endtask

    task automatic load_image();
        for (int i = 0; i < 64; i++) mem[i] = 8'hAA;
        put_rec(0,  16'h0010, 32'h11223344, 1);
        put_rec(6,  16'h3FFE, 32'hDEADBEEF, 1);
        put_rec(12, 16'h0002, 32'hFFFFFFFF, 1);
        mem[18] = 8'hFF; mem[19] = 8'hFF;
    endtask

    task automatic run(input bit hot, input bit slow, input logic [3:0] mode,
                       input logic [3:0] strap, input logic [3:0] slave_strap);
        @(negedge clk);
        slow_strap = slow; mode_strap = mode; addr_strap = strap;
        if (hot) hot_rst = 1'b1; else rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!done && !error && !scl_oe && !sda_oe, "R7 reset clears outputs", {done, error, scl_oe, sda_oe}, 0);
        clear_mon();
        s_addr = {3'b101, slave_strap};
        rst = 1'b0; hot_rst = 1'b0;
    endtask

    task automatic wait_done();
        int w = 0;
        while (!done && w < 40000) begin @(negedge clk); w++; end
        chk(done, "R5 done reached", done, 1);
    endtask

    task automatic check_load(input logic [3:0] strap, input int q, input string tag);
        chk(wq.size() == 4, "R3 written byte count", wq.size(), 4);
        if (wq.size() == 4) begin
            chk(wq[0] == {3'b101, strap, 1'b0}, "R2 address byte write", wq[0], {3'b101, strap, 1'b0});
            chk(wq[1] == 8'h00 && wq[2] == 8'h00, "R3 offset bytes", {wq[1], wq[2]}, 0);
            chk(wq[3] == {3'b101, strap, 1'b1}, "R2 address byte read", wq[3], {3'b101, strap, 1'b1});
        end
        chk(n_start == 2, "R3 START count (R9 no stray edges)", n_start, 2);
        chk(n_stop == 1, "R5 STOP count", n_stop, 1);
        chk(n_rd == 21, "R5 bytes read", n_rd, 21);
        chk(last_nack, "R5 final NACK", last_nack, 1);
        chk(!error, "R5 error low", error, 0);
        chk(hq.size() > 4 && hq[3] == 2 * q, {"R1 SCL high time ", tag}, hq.size() > 4 ? hq[3] : -1, 2 * q);
        chk(hq.size() > 4 && hq[4] == 2 * q, {"R9 mid-high sample window ", tag}, hq.size() > 4 ? hq[4] : -1, 2 * q);
        chk(n_we == 3 && expq.size() == 0, "R4 write count", n_we, 3);
        repeat (20) @(negedge clk);
        chk(done, "R10 done holds", done, 1);
    endtask

    initial begin
        load_image();
        repeat (4) @(negedge clk);
        chk(!done && !error && !reg_we && !scl_oe && !sda_oe, "R7 reset state",
            {done, error, reg_we, scl_oe, sda_oe}, 0);

        // fundamental reset, fast rate, mode 1
        run(0, 0, 4'd1, 4'b0011, 4'b0011);
        wait_done();
        check_load(4'b0011, QF, "fast");

        // hot reset, slow rate, mode 3, other address
        load_image();
        run(1, 1, 4'd3, 4'b0110, 4'b0110);
        wait_done();
        check_load(4'b0110, QS, "slow");

        // mode not in the load set
        run(0, 0, 4'd2, 4'b0011, 4'b0011);
        @(negedge clk);
        @(negedge clk);
        chk(done && !error, "R6 immediate done", {done, error}, 2'b10);
        repeat (30) @(negedge clk);
        chk(scl_act == 0 && n_start == 0, "R6 bus untouched", scl_act, 0);
        chk(n_we == 0, "R6 no writes", n_we, 0);

        // device address not acknowledged
        run(0, 0, 4'd1, 4'b0101, 4'b0011);
        wait_done();
        chk(error, "R8 error raised", error, 1);
        chk(wq.size() == 1 && wq[0] == 8'hAA, "R8 single address byte", wq.size() > 0 ? wq[0] : 0, 8'hAA);
        chk(n_start == 1 && n_stop == 1, "R8 STOP after NACK", {n_start[7:0], n_stop[7:0]}, 16'h0101);
        chk(n_we == 0, "R8 no writes", n_we, 0);
        repeat (10) @(negedge clk);
        chk(done && error, "R10 done and error hold", {done, error}, 2'b11);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule